// File: doc/BRIEF.md
# ATA Task-File Register Set

This block holds the host-visible register file of a legacy IDE-style disk interface. A host reaches it over a byte-wide register bus. Each access is a single-cycle strobe that carries a 3-bit offset and a block select, which picks either the command block or the control block. Three of the command registers are two-byte shift FIFOs: the sector count, the low address byte and the high address byte. This lets a host stage the extra bytes of a 48-bit address by writing each register twice. A selector bit in the control register picks which of the two bytes comes back on a read.

One control-block offset acts as two registers. A write stores the device control bits: byte selector, software reset and interrupt mask. A read returns a copy of the device status that leaves any pending interrupt in place. The device side is modelled by three inputs: a status byte, a ready level and an interrupt pulse. The block drives a masked host interrupt and a reset level toward the device.

Command-block layout: offset 1 holds the features byte (read/write). Offsets 2, 3 and 4 are the sector-count, low-address and high-address FIFOs. Offset 5 is the device/head byte. A read of offset 7 returns status; a write there is a command. Offsets 0 and 6 read as zero, and writes to them are not stored. In the control block, only offset 2 is decoded. The other control offsets read as zero and ignore writes.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After reset, host_irq and dev_srst are 0, the byte selector is 0, and every FIFO register reads 0x00.
- R2: Each write to a FIFO register (command offsets 2, 3, 4) moves its newer byte into the older slot and stores the written byte as the newer one. With the selector at 0, a read returns the newer byte.
- R3: Writing control offset 2 with bit 7 = 1 sets the selector. While it is 1, FIFO reads return the older byte.
- R4: Any write to a command-block offset clears the selector to 0.
- R5: A read of control offset 2 returns the status value (the same value as command offset 7), never the stored control bits.
- R6: In a control write, bits 6..3 and bit 0 have no effect on reset, masking or the selector.
- R7: Control bit 2 drives dev_srst. dev_srst rises the cycle after a write with the bit set and stays 1 until a control write clears the bit.
- R8: While the reset bit is 1, status bit 7 (busy) reads 1. After the bit is cleared, busy keeps reading 1 until dev_ready is seen high. Other status bits come from dev_status.
- R9: Control bit 1 = 1 masks host_irq. A pending interrupt reappears on host_irq once the bit is written back to 0.
- R10: A dev_irq pulse sets a pending flag, and host_irq equals the pending flag when unmasked. A status read at command offset 7 clears the flag; a read at control offset 2 does not.
- R11: While the reset bit is 1, the three FIFOs, the features byte and the pending flag are held at zero, and writes to them are lost.
- R12: acc_rdata updates on the clock edge that samples a read strobe and holds its value through all other cycles, writes included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_stb | input | 1 | Single-cycle access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_ctl | input | 1 | 1 = control block, 0 = command block |
| acc_addr | input | 3 | Register offset within the block |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Registered read byte |
| dev_status | input | 8 | Status byte presented by the device |
| dev_ready | input | 1 | Device has finished its reset |
| dev_irq | input | 1 | Device interrupt pulse |
| host_irq | output | 1 | Masked interrupt to the host |
| dev_srst | output | 1 | Software reset level to the device |

## Verification
The hardest state to reach is the window after the reset bit is cleared but before the device reports ready. Status must still show busy there, even though nothing on the bus asserts reset any more. The stimulus holds dev_ready low through a full reset cycle, reads status on both sides of the release, and only then raises dev_ready. The byte selector is driven through interleaved control and command writes, so the bench can see whether any command write has silently dropped it. The two status locations are read back to back against a pending interrupt, which separates the read that clears the flag from the one that must not.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned FIFO_DEP = 2;
  localparam int unsigned NUM_FIFO = 3;

  // command block offsets
  localparam logic [ADDR_W-1:0] CMD_FEAT  = 3'd1;
  localparam logic [ADDR_W-1:0] FIFO_BASE = 3'd2;
  localparam logic [ADDR_W-1:0] CMD_DEVH  = 3'd5;
  localparam logic [ADDR_W-1:0] CMD_STAT  = 3'd7;
  // control block offset
  localparam logic [ADDR_W-1:0] CTL_DEVC  = 3'd2;

  // control bit positions
  localparam int unsigned DC_HOB  = 7;
  localparam int unsigned DC_SRST = 2;
  localparam int unsigned DC_NIEN = 1;
  // status busy bit
  localparam int unsigned ST_BSY  = 7;

  function automatic logic [ADDR_W-1:0] fifo_offset(input int unsigned idx);
    return FIFO_BASE + ADDR_W'(idx);
  endfunction
endpackage

// File: rtl/tf_byte_fifo.sv
module tf_byte_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         old_sel,
  output logic [W-1:0] rdata
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [W-1:0] slot_q [DEPTH];
  logic [W-1:0] slot_d [DEPTH];
  logic         slot_en;

  assign slot_en = clr | wr_en;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) slot_d[i] = '0;
    end else if (wr_en) begin
      slot_d[0] = wdata;
      for (int i = 1; i < DEPTH; i++) slot_d[i] = slot_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (slot_en) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
    end
  end

  assign rdata = old_sel ? slot_q[LAST] : slot_q[0];

  // newest byte moves one slot up on a write
  generate
    if (DEPTH > 1) begin : g_shift_chk
      p_fifo_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (slot_q[1] == $past(slot_q[0])));
    end
  endgenerate

  p_fifo_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (slot_q[0] == '0));
endmodule

// File: rtl/tf_devctl.sv
module tf_devctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic cmd_wr,
  input  logic hob_in,
  input  logic srst_in,
  input  logic nien_in,
  input  logic dev_ready,
  output logic hob,
  output logic srst,
  output logic nien,
  output logic busy
);
  logic hob_q, hob_d, hob_en;
  logic srst_q, nien_q;
  logic bsy_q, bsy_d, bsy_en;

  assign hob_en = ctl_wr | cmd_wr;
  always_comb begin
    hob_d = hob_q;
    if (ctl_wr)      hob_d = hob_in;
    else if (cmd_wr) hob_d = 1'b0;
  end

  // busy stays latched from reset until the device reports ready
  assign bsy_en = srst_q | dev_ready;
  always_comb begin
    bsy_d = bsy_q;
    if (srst_q)         bsy_d = 1'b1;
    else if (dev_ready) bsy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hob_q  <= 1'b0;
      srst_q <= 1'b0;
      nien_q <= 1'b0;
      bsy_q  <= 1'b0;
    end else begin
      if (hob_en) hob_q <= hob_d;
      if (ctl_wr) begin
        srst_q <= srst_in;
        nien_q <= nien_in;
      end
      if (bsy_en) bsy_q <= bsy_d;
    end
  end

  assign hob  = hob_q;
  assign srst = srst_q;
  assign nien = nien_q;
  assign busy = srst_q | bsy_q;

  p_cmdwr_clears_hob_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !ctl_wr) |=> !hob);
  p_srst_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (srst && !ctl_wr) |=> srst);
  p_busy_until_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dev_ready) |=> busy);
endmodule

// File: rtl/tf_irq.sv
module tf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_irq,
  input  logic stat_rd,
  input  logic srst,
  input  logic nien,
  output logic pending,
  output logic host_irq
);
  logic pend_q, pend_d, pend_en;

  assign pend_en = srst | dev_irq | stat_rd;
  always_comb begin
    pend_d = pend_q;
    if (srst)         pend_d = 1'b0;
    else if (dev_irq) pend_d = 1'b1;
    else if (stat_rd) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pending  = pend_q;
  assign host_irq = pend_q & ~nien;

  p_status_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !dev_irq && !srst) |=> !pending);
  p_srst_drops_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !host_irq);
  p_pulse_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_irq && !srst) |=> pending);
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
  import ata_tf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_stb,
  input  logic              acc_wr,
  input  logic              acc_ctl,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BYTE_W-1:0] acc_wdata,
  output logic [BYTE_W-1:0] acc_rdata,
  input  logic [BYTE_W-1:0] dev_status,
  input  logic              dev_ready,
  input  logic              dev_irq,
  output logic              host_irq,
  output logic              dev_srst
);
  logic cmd_wr, cmd_rd, ctl_wr, ctl_rd;
  logic devc_wr, stat_rd, alt_rd;
  logic hob, srst, nien, busy, pending;
  logic [BYTE_W-1:0] status_val;
  logic [BYTE_W-1:0] fifo_rd [NUM_FIFO];
  logic [BYTE_W-1:0] feat_q, feat_d, devh_q;
  logic              feat_en, devh_en;
  logic [BYTE_W-1:0] rd_mux, rdata_q;

  assign cmd_wr  = acc_stb &  acc_wr & ~acc_ctl;
  assign cmd_rd  = acc_stb & ~acc_wr & ~acc_ctl;
  assign ctl_wr  = acc_stb &  acc_wr &  acc_ctl;
  assign ctl_rd  = acc_stb & ~acc_wr &  acc_ctl;
  assign devc_wr = ctl_wr & (acc_addr == CTL_DEVC);
  assign stat_rd = cmd_rd & (acc_addr == CMD_STAT);
  assign alt_rd  = ctl_rd & (acc_addr == CTL_DEVC);

  tf_devctl u_devctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (devc_wr),
    .cmd_wr    (cmd_wr),
    .hob_in    (acc_wdata[DC_HOB]),
    .srst_in   (acc_wdata[DC_SRST]),
    .nien_in   (acc_wdata[DC_NIEN]),
    .dev_ready (dev_ready),
    .hob       (hob),
    .srst      (srst),
    .nien      (nien),
    .busy      (busy)
  );

  tf_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_irq  (dev_irq),
    .stat_rd  (stat_rd),
    .srst     (srst),
    .nien     (nien),
    .pending  (pending),
    .host_irq (host_irq)
  );

  generate
    for (genvar g = 0; g < NUM_FIFO; g++) begin : g_fifo
      tf_byte_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEP)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (srst),
        .wr_en   (cmd_wr & (acc_addr == fifo_offset(g))),
        .wdata   (acc_wdata),
        .old_sel (hob),
        .rdata   (fifo_rd[g])
      );
    end
  endgenerate

  // features byte: cleared while reset is held
  assign feat_en = srst | (cmd_wr & (acc_addr == CMD_FEAT));
  assign feat_d  = srst ? '0 : acc_wdata;
  assign devh_en = cmd_wr & (acc_addr == CMD_DEVH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feat_q <= '0;
      devh_q <= '0;
    end else begin
      if (feat_en) feat_q <= feat_d;
      if (devh_en) devh_q <= acc_wdata;
    end
  end

  always_comb begin
    status_val         = dev_status;
    status_val[ST_BSY] = dev_status[ST_BSY] | busy;
  end

  always_comb begin
    rd_mux = '0;
    if (acc_ctl) begin
      if (acc_addr == CTL_DEVC) rd_mux = status_val;
    end else begin
      if (acc_addr == CMD_FEAT) rd_mux = feat_q;
      if (acc_addr == CMD_DEVH) rd_mux = devh_q;
      if (acc_addr == CMD_STAT) rd_mux = status_val;
      for (int i = 0; i < NUM_FIFO; i++)
        if (acc_addr == fifo_offset(i)) rd_mux = fifo_rd[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rdata_q <= '0;
    else if (cmd_rd | ctl_rd)  rdata_q <= rd_mux;
  end

  assign acc_rdata = rdata_q;
  assign dev_srst  = srst;

  p_alt_keeps_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_rd && pending && !srst) |=> pending);
  p_status_busy_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && dev_srst) |=> acc_rdata[ST_BSY]);
  p_rdata_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_stb && !acc_wr) |=> $stable(acc_rdata));
  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (devc_wr && acc_wdata[DC_NIEN]) |=> !host_irq);
endmodule

// File: tb/ata_taskfile_regs_tb.sv
`timescale 1ns/1ps
module ata_taskfile_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_stb, acc_wr, acc_ctl;
  logic [2:0] acc_addr;
  logic [7:0] acc_wdata, acc_rdata, dev_status;
  logic       dev_ready, dev_irq, host_irq, dev_srst;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       mon_due = 1'b0;

  always #2 clk = ~clk;

  ata_taskfile_regs dut_i (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_wr(acc_wr),
    .acc_ctl(acc_ctl), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .dev_status(dev_status), .dev_ready(dev_ready),
    .dev_irq(dev_irq), .host_irq(host_irq), .dev_srst(dev_srst)
  );

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // monitor: compares read data one edge after each read strobe
  always @(posedge clk) mon_due <= acc_stb & ~acc_wr;
  always @(negedge clk) begin
    if (mon_due && exp_q.size() > 0) begin
      logic [7:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(acc_rdata, e, t);
    end
  end

  task automatic wr(input logic ctl, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_stb = 1; acc_wr = 1; acc_ctl = ctl; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_stb = 0; acc_wr = 0;
  endtask

  task automatic rd(input logic ctl, input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    acc_stb = 1; acc_wr = 0; acc_ctl = ctl; acc_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    acc_stb = 0;
  endtask

  task automatic irq_pulse();
    @(negedge clk); dev_irq = 1;
    @(negedge clk); dev_irq = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; acc_stb = 0; acc_wr = 0; acc_ctl = 0; acc_addr = 0; acc_wdata = 0;
    dev_status = 8'h50; dev_ready = 1; dev_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check({7'd0, host_irq}, 8'h00, "R1 host_irq");
    check({7'd0, dev_srst}, 8'h00, "R1 dev_srst");
    rd(0, 3'd2, 8'h00, "R1 fifo empty");

    // R2 shift, R3 older byte, R4 command write clears selector
    wr(0, 3'd2, 8'h11);
    wr(0, 3'd2, 8'h22);
    rd(0, 3'd2, 8'h22, "R2 newer byte");
    wr(1, 3'd2, 8'h80);
    rd(0, 3'd2, 8'h11, "R3 older byte");
    wr(0, 3'd3, 8'hA1);
    wr(0, 3'd3, 8'hB2);
    wr(1, 3'd2, 8'h80);
    rd(0, 3'd3, 8'hA1, "R3 older lba low");
    wr(0, 3'd4, 8'h5C);
    rd(0, 3'd3, 8'hB2, "R4 selector cleared");
    rd(0, 3'd4, 8'h5C, "R2 lba high newer");
    wr(1, 3'd2, 8'h80);
    rd(0, 3'd4, 8'h00, "R2 lba high older");

    // R5 alternate status
    rd(1, 3'd2, 8'h50, "R5 alt status");
    rd(0, 3'd7, 8'h50, "R5 status");

    // R10 pending flag and the two status reads
    irq_pulse();
    @(negedge clk);
    check({7'd0, host_irq}, 8'h01, "R10 irq raised");
    rd(1, 3'd2, 8'h50, "R10 alt read");
    @(negedge clk);
    check({7'd0, host_irq}, 8'h01, "R10 alt keeps irq");
    rd(0, 3'd7, 8'h50, "R10 status read");
    @(negedge clk);
    check({7'd0, host_irq}, 8'h00, "R10 status clears irq");

    // R9 masking
    wr(1, 3'd2, 8'h02);
    irq_pulse();
    @(negedge clk);
    check({7'd0, host_irq}, 8'h00, "R9 masked");
    wr(1, 3'd2, 8'h00);
    @(negedge clk);
    check({7'd0, host_irq}, 8'h01, "R9 unmasked pending");
    rd(0, 3'd7, 8'h50, "R9 clear status");

    // R6 reserved control bits
    wr(0, 3'd2, 8'h33);
    irq_pulse();
    wr(1, 3'd2, 8'h79);
    @(negedge clk);
    check({7'd0, dev_srst}, 8'h00, "R6 no reset");
    check({7'd0, host_irq}, 8'h01, "R6 no mask");
    rd(0, 3'd2, 8'h33, "R6 selector low");
    rd(0, 3'd7, 8'h50, "R6 clear status");

    // R7 R8 R11 software reset
    wr(0, 3'd1, 8'h9E);
    rd(0, 3'd1, 8'h9E, "R11 features set");
    dev_ready = 0;
    irq_pulse();
    wr(1, 3'd2, 8'h04);
    @(negedge clk);
    check({7'd0, dev_srst}, 8'h01, "R7 reset asserted");
    check({7'd0, host_irq}, 8'h00, "R11 irq cleared");
    rd(0, 3'd7, 8'hD0, "R8 busy in reset");
    rd(0, 3'd2, 8'h00, "R11 fifo cleared");
    rd(0, 3'd1, 8'h00, "R11 features cleared");
    wr(0, 3'd2, 8'h44);
    rd(0, 3'd2, 8'h00, "R11 write lost");
    check({7'd0, dev_srst}, 8'h01, "R7 reset held");
    wr(1, 3'd2, 8'h00);
    @(negedge clk);
    check({7'd0, dev_srst}, 8'h00, "R7 reset released");
    rd(1, 3'd2, 8'hD0, "R8 busy before ready");
    dev_ready = 1;
    repeat (2) @(negedge clk);
    rd(0, 3'd7, 8'h50, "R8 busy gone");

    // R12 registered read data holds
    wr(0, 3'd2, 8'h66);
    rd(0, 3'd2, 8'h66, "R12 read value");
    wr(0, 3'd2, 8'h77);
    @(negedge clk);
    check(acc_rdata, 8'h66, "R12 held over write");

    repeat (3) @(negedge clk);
    check(8'(exp_q.size()), 8'h00, "R12 scoreboard drained");
    finish_run();
  end
endmodule